// File: doc/BRIEF.md
# Descriptor Command Sequencer

This block is the command engine of one channel of a descriptor-driven DMA controller. While the channel is both running and active, the engine reads a 16-byte command descriptor from memory at the current command pointer and decodes it. It then carries the command out. Data-transfer commands are handed to an external data mover through a start/done handshake. When the mover finishes, the engine writes the status word and the residual count back into the descriptor. Word commands move one to four bytes between memory and the descriptor's dependent field. A no-op command only runs the flow logic, and a stop command parks the channel.

After each command, three 2-bit selectors in the command word decide what happens next. The first decides whether an interrupt pulse is raised. The second decides whether the channel waits on the same descriptor. The third decides whether the pointer branches to the dependent field or steps to the next descriptor. Each selector is tested against one condition bit, formed from the low status bits and a mask/value pair held in the dependent word. The status register itself lives in a neighbouring control block. This engine reads it and sends it one-cycle set and clear pulses.

Descriptor layout in memory, little-endian, as four 32-bit words at pointer offsets:
- +0: request count in bits 15:0, command word in bits 31:16.
- +4: data address.
- +8: dependent word.
- +12: residual count in bits 15:0, transfer status in bits 31:16.

Top module: `dsq_top`

## Requirements
- R1: While idle with RUN (status bit 15) and ACTIVE (status bit 10) both set, the engine pulses `wake_clr` for one cycle. It then reads the four descriptor words at pointer +0, +4, +8 and +12, holding each request and its address until `mem_ack`.
- R2: No fetch starts unless RUN and ACTIVE are both 1. With either bit at 0, `mem_req` stays low.
- R3: Command word fields: opcode in bits 15:12, key in bits 10:8, interrupt selector in bits 5:4, branch selector in bits 3:2, wait selector in bits 1:0. Opcodes 0, 1, 2 and 3 are out-more, out-last, in-more and in-last. Each pulses `xfer_start` once, with `xfer_addr` set to the data address and `xfer_len` set to the request count. `xfer_in` is 1 for opcodes 2 and 3, and `xfer_last` is 1 for opcodes 1 and 3.
- R4: A transfer command whose data address is 0 or whose key is above 3, and any opcode from 8 to 15, kills the channel. `dead_set` and `active_clr` pulse together. There is no transfer, no writeback and no interrupt, and the pointer does not move.
- R5: On `xfer_done`, the word at pointer +12 is written with the status input sampled in the done cycle in bits 31:16 and `xfer_resid` in bits 15:0. This happens before the pointer moves.
- R6: The condition bit is true when (status[3:0] AND dep[19:16]) equals (dep[3:0] AND dep[19:16]). Selector code 0 means never, 1 means when the condition is true, 2 means when it is false, and 3 means always.
- R7: After a transfer's writeback, a word command, or a no-op, `irq` pulses for exactly one cycle if the interrupt selector fires.
- R8: The wait selector is tested before the branch selector. While it fires, the pointer stays on the same descriptor and nothing is re-executed. When it stops firing, the engine advances. If RUN or ACTIVE drops during the wait, the engine returns to idle without advancing.
- R9: If the branch selector fires, the pointer is loaded from the dependent word and `bt_set` pulses. Otherwise the pointer steps by 16. Word commands always step by 16.
- R10: Opcode 7 (stop) pulses `active_clr`, leaves the pointer unchanged and raises no interrupt.
- R11: Opcodes 4 (store-word) and 5 (load-word) access memory only with key 6. The request count selects the size: 1 byte, 2 bytes, or otherwise 4 bytes, at the data address rounded down to that size. A load replaces the low bytes of the dependent word and writes it back to pointer +8. A store writes the low bytes of the dependent word. With any other key there is no memory access and the engine steps on.
- R12: `ptr_load` replaces the pointer with `ptr_wr` only while the engine is idle and not starting. At any other time it is ignored.
- R13: After reset the pointer is 0 and `mem_req`, `xfer_start`, `irq` and all status pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_i | input | 16 | Channel status word from the control block |
| ptr_load | input | 1 | Load the command pointer (idle only) |
| ptr_wr | input | 32 | Value for a pointer load |
| cmd_ptr | output | 32 | Current command pointer |
| wake_clr | output | 1 | Pulse: clear the wake bit (descriptor fetch begins) |
| bt_set | output | 1 | Pulse: set the branch-taken bit |
| dead_set | output | 1 | Pulse: set the dead bit |
| active_clr | output | 1 | Pulse: clear the active bit |
| irq | output | 1 | One-cycle interrupt pulse |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| xfer_start | output | 1 | Pulse: start a device transfer |
| xfer_in | output | 1 | Transfer direction, 1 = device to memory |
| xfer_last | output | 1 | Transfer is the last of its packet |
| xfer_addr | output | 32 | Transfer data address |
| xfer_len | output | 16 | Transfer byte count |
| xfer_done | input | 1 | Pulse: transfer finished |
| xfer_resid | input | 16 | Bytes not transferred, valid with `xfer_done` |

## Verification
Each memory access takes one cycle of request, then an acknowledge the memory model returns one cycle later. A fetch therefore needs eight cycles. The transfer start pulse appears one cycle after the fourth fetch word. A flow decision follows the acknowledge of the final write by one cycle, and the pointer register updates at the next edge. Because these delays depend on the memory and device models, the bench does not count to fixed cycles. It waits, with a bound, for the channel's ACTIVE bit to fall at the stop descriptor that ends every chain. It then samples the pointer, the memory image and the pulse counters on a falling edge. Hold and ignore cases are observed after a fixed dwell of tens of cycles, far longer than any single access.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

  localparam int WORD_W     = 32;
  localparam int HALF_W     = 16;
  localparam int DESC_BYTES = 16;
  localparam int DESC_WORDS = DESC_BYTES / 4;
  localparam int IDX_W      = $clog2(DESC_WORDS);
  localparam int COND_W     = 4;
  localparam int MASK_LSB   = 16;

  localparam int RUN_BIT    = 15;
  localparam int ACT_BIT    = 10;

  localparam logic [2:0] KEY_STREAM_MAX = 3'd3;
  localparam logic [2:0] KEY_SYSTEM     = 3'd6;

  localparam logic [1:0] SEL_NEVER  = 2'd0;
  localparam logic [1:0] SEL_IFTRUE = 2'd1;
  localparam logic [1:0] SEL_IFFALS = 2'd2;
  localparam logic [1:0] SEL_ALWAYS = 2'd3;

  typedef enum logic [3:0] {
    OP_OUT_MORE = 4'd0,
    OP_OUT_LAST = 4'd1,
    OP_IN_MORE  = 4'd2,
    OP_IN_LAST  = 4'd3,
    OP_STORE_W  = 4'd4,
    OP_LOAD_W   = 4'd5,
    OP_NOP      = 4'd6,
    OP_STOP     = 4'd7
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_EXEC, S_XFER, S_WB, S_WORD, S_DEPWB, S_FIN, S_HOLD
  } state_e;

  typedef struct packed {
    logic [3:0] op;
    logic       rsv0;
    logic [2:0] key;
    logic [1:0] rsv1;
    logic [1:0] isel;
    logic [1:0] bsel;
    logic [1:0] wsel;
  } cmd_t;

endpackage

// File: rtl/dsq_cond_sel.sv
module dsq_cond_sel (
  input  logic [1:0] sel,
  input  logic       cond,
  output logic       fire
);
  import dsq_pkg::*;

  always_comb begin
    unique case (sel)
      SEL_NEVER:  fire = 1'b0;
      SEL_IFTRUE: fire = cond;
      SEL_IFFALS: fire = ~cond;
      default:    fire = 1'b1;
    endcase
  end

endmodule

// File: rtl/dsq_desc_store.sv
module dsq_desc_store #(
  parameter int KEEP = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cap_en,
  input  logic [dsq_pkg::IDX_W-1:0] cap_idx,
  input  logic [dsq_pkg::WORD_W-1:0] cap_data,
  input  logic                      dep_wr,
  input  logic [dsq_pkg::WORD_W-1:0] dep_data,
  output logic [dsq_pkg::WORD_W-1:0] word_q [KEEP]
);
  import dsq_pkg::*;

  localparam int DEP_IDX = 2;

  for (genvar i = 0; i < KEEP; i++) begin : g_word
    logic            en;
    logic [WORD_W-1:0] nxt;

    if (i == DEP_IDX) begin : g_dep
      assign en  = dep_wr | (cap_en && cap_idx == IDX_W'(i));
      assign nxt = dep_wr ? dep_data : cap_data;
    end else begin : g_plain
      assign en  = cap_en && cap_idx == IDX_W'(i);
      assign nxt = cap_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word_q[i] <= '0;
      else if (en) word_q[i] <= nxt;
    end
  end

endmodule

// File: rtl/dsq_top.sv
module dsq_top #(
  parameter int PTR_STEP = dsq_pkg::DESC_BYTES
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] stat_i,
  input  logic        ptr_load,
  input  logic [31:0] ptr_wr,
  output logic [31:0] cmd_ptr,
  output logic        wake_clr,
  output logic        bt_set,
  output logic        dead_set,
  output logic        active_clr,
  output logic        irq,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        xfer_start,
  output logic        xfer_in,
  output logic        xfer_last,
  output logic [31:0] xfer_addr,
  output logic [15:0] xfer_len,
  input  logic        xfer_done,
  input  logic [15:0] xfer_resid
);
  import dsq_pkg::*;

  localparam int KEEP = 3;
  localparam int NSEL = 3;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  state_e            state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [31:0]       ptr_q, ptr_d;
  logic [15:0]       resid_q, resid_d;
  logic [15:0]       snap_q, snap_d;
  logic              seq_q, seq_d;

  logic [WORD_W-1:0] dw [KEEP];
  logic              cap_en, dep_wr;
  logic [31:0]       dep_new;
  cmd_t              cmd;
  logic [31:0]       daddr, dep;
  logic [15:0]       req_cnt;

  assign req_cnt = dw[0][15:0];
  assign cmd     = cmd_t'(dw[0][31:16]);
  assign daddr   = dw[1];
  assign dep     = dw[2];

  dsq_desc_store #(.KEEP(KEEP)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .cap_idx  (idx_q),
    .cap_data (mem_rdata),
    .dep_wr   (dep_wr),
    .dep_data (dep_new),
    .word_q   (dw)
  );

  // condition bit and the three selectors (interrupt, branch, wait)
  logic [COND_W-1:0] c_mask, c_val;
  logic              cond;
  logic [1:0]        sel [NSEL];
  logic [NSEL-1:0]   fire;

  assign c_mask = dep[MASK_LSB +: COND_W];
  assign c_val  = dep[COND_W-1:0];
  assign cond   = (stat_i[COND_W-1:0] & c_mask) == (c_val & c_mask);
  assign sel[0] = cmd.isel;
  assign sel[1] = cmd.bsel;
  assign sel[2] = cmd.wsel;

  for (genvar s = 0; s < NSEL; s++) begin : g_sel
    dsq_cond_sel u_sel (.sel(sel[s]), .cond(cond), .fire(fire[s]));
  end

  logic go, is_xfer_op, xfer_bad, is_store, word_ok;
  assign go         = stat_i[RUN_BIT] & stat_i[ACT_BIT];
  assign is_xfer_op = (cmd.op[3:2] == 2'b00);
  assign xfer_bad   = (daddr == '0) || (cmd.key > KEY_STREAM_MAX);
  assign is_store   = (cmd.op == OP_STORE_W);
  assign word_ok    = (cmd.key == KEY_SYSTEM);

  // word command lane selection
  logic [1:0]  eff_off;
  logic [3:0]  word_be;
  logic [31:0] rd_shift;
  always_comb begin
    if (req_cnt == 16'd1) begin
      eff_off = daddr[1:0];
      word_be = 4'b0001 << daddr[1:0];
    end else if (req_cnt == 16'd2) begin
      eff_off = {daddr[1], 1'b0};
      word_be = 4'b0011 << {daddr[1], 1'b0};
    end else begin
      eff_off = 2'd0;
      word_be = 4'b1111;
    end
    rd_shift = mem_rdata >> {eff_off, 3'b000};
    if (req_cnt == 16'd1)      dep_new = {dep[31:8], rd_shift[7:0]};
    else if (req_cnt == 16'd2) dep_new = {dep[31:16], rd_shift[15:0]};
    else                       dep_new = rd_shift;
  end

  assign xfer_addr = daddr;
  assign xfer_len  = req_cnt;
  assign xfer_in   = cmd.op[1];
  assign xfer_last = cmd.op[0];
  assign cmd_ptr   = ptr_q;

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    ptr_d      = ptr_q;
    resid_d    = resid_q;
    snap_d     = snap_q;
    seq_d      = seq_q;
    cap_en     = 1'b0;
    dep_wr     = 1'b0;
    wake_clr   = 1'b0;
    bt_set     = 1'b0;
    dead_set   = 1'b0;
    active_clr = 1'b0;
    irq        = 1'b0;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = ptr_q;
    mem_be     = 4'b1111;
    mem_wdata  = '0;
    xfer_start = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (go) begin
          wake_clr = 1'b1;
          idx_d    = '0;
          state_d  = S_FETCH;
        end else if (ptr_load) begin
          ptr_d = ptr_wr;
        end
      end
      S_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = ptr_q + {28'd0, idx_q, 2'b00};
        if (mem_ack) begin
          cap_en = 1'b1;
          if (idx_q == LAST_IDX) state_d = S_EXEC;
          else                   idx_d   = idx_q + 1'b1;
        end
      end
      S_EXEC: begin
        if (is_xfer_op && !xfer_bad) begin
          xfer_start = 1'b1;
          seq_d      = 1'b0;
          state_d    = S_XFER;
        end else if (cmd.op == OP_STORE_W || cmd.op == OP_LOAD_W) begin
          seq_d   = 1'b1;
          state_d = word_ok ? S_WORD : S_FIN;
        end else if (cmd.op == OP_NOP) begin
          seq_d   = 1'b0;
          state_d = S_FIN;
        end else if (cmd.op == OP_STOP) begin
          active_clr = 1'b1;
          state_d    = S_IDLE;
        end else begin
          dead_set   = 1'b1;
          active_clr = 1'b1;
          state_d    = S_IDLE;
        end
      end
      S_XFER: begin
        if (xfer_done) begin
          resid_d = xfer_resid;
          snap_d  = stat_i;
          state_d = S_WB;
        end
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ptr_q + 32'd12;
        mem_wdata = {snap_q, resid_q};
        if (mem_ack) state_d = S_FIN;
      end
      S_WORD: begin
        mem_req   = 1'b1;
        mem_we    = is_store;
        mem_addr  = {daddr[31:2], 2'b00};
        mem_be    = word_be;
        mem_wdata = dep << {eff_off, 3'b000};
        if (mem_ack) begin
          dep_wr  = ~is_store;
          state_d = is_store ? S_FIN : S_DEPWB;
        end
      end
      S_DEPWB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ptr_q + 32'd8;
        mem_wdata = dep;
        if (mem_ack) state_d = S_FIN;
      end
      S_FIN, S_HOLD: begin
        irq = (state_q == S_FIN) & fire[0];
        if (state_q == S_HOLD && !go) begin
          state_d = S_IDLE;
        end else if (fire[2]) begin
          state_d = S_HOLD;
        end else begin
          state_d = S_IDLE;
          if (!seq_q && fire[1]) begin
            ptr_d  = dep;
            bt_set = 1'b1;
          end else begin
            ptr_d = ptr_q + 32'(PTR_STEP);
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      ptr_q   <= '0;
      resid_q <= '0;
      snap_q  <= '0;
      seq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      ptr_q   <= ptr_d;
      resid_q <= resid_d;
      snap_q  <= snap_d;
      seq_q   <= seq_d;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{cmd.rsv0, cmd.rsv1, stat_i[14:11], stat_i[9:4],
                         dep[31:20], dep[15:4]};

  // R1: an open memory request keeps its address until acknowledged
  a_r1_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R1: a wake clear is followed by the fetch of word 0 at the pointer
  a_r1_fetch_start: assert property (@(posedge clk) disable iff (!rst_n)
    wake_clr |=> mem_req && !mem_we && mem_addr == cmd_ptr);

  // R3: transfer start is a single-cycle pulse
  a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  // R4: a kill leaves the pointer and issues no memory request
  a_r4_kill_stays: assert property (@(posedge clk) disable iff (!rst_n)
    dead_set |=> cmd_ptr == $past(cmd_ptr) && !mem_req);

  // R7: interrupt is a single-cycle pulse
  a_r7_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R9: a taken branch loads the dependent word
  a_r9_branch_target: assert property (@(posedge clk) disable iff (!rst_n)
    bt_set |=> cmd_ptr == $past(dep));

  // R10: deactivation leaves the pointer where it was
  a_r10_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    active_clr |=> $stable(cmd_ptr));

endmodule

// File: tb/dsq_top_tb.sv
`timescale 1ns/1ps
module dsq_top_tb;

  logic        clk, rst_n;
  logic [15:0] stat_i;
  logic        ptr_load;
  logic [31:0] ptr_wr, cmd_ptr;
  logic        wake_clr, bt_set, dead_set, active_clr, irq;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        xfer_start, xfer_in, xfer_last, xfer_done;
  logic [31:0] xfer_addr;
  logic [15:0] xfer_len, xfer_resid;

  dsq_top u_dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int total = 0, bad = 0;
  logic done_flag = 1'b0;

  // control block model
  logic       run_r, act_set, active_q;
  logic [3:0] dev_r;
  assign stat_i = {run_r, 4'b0, active_q, 6'b0, dev_r};
  always @(posedge clk or negedge rst_n)
    if (!rst_n) active_q <= 1'b0;
    else if (active_clr) active_q <= 1'b0;
    else if (act_set) active_q <= 1'b1;

  // memory model: 1024 words, low 12 address bits decoded
  logic [31:0] mem [1024];
  int n_wr = 0;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_addr[11:2]];
        if (mem_we) begin
          n_wr <= n_wr + 1;
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        end
      end
    end

  // device model
  int dcnt;
  logic [31:0] cap_addr; logic [15:0] cap_len; logic cap_in, cap_last;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin dcnt <= 0; xfer_done <= 1'b0; end
    else begin
      xfer_done <= 1'b0;
      if (xfer_start) begin
        dcnt <= 3; cap_addr <= xfer_addr; cap_len <= xfer_len;
        cap_in <= xfer_in; cap_last <= xfer_last;
      end else if (dcnt != 0) begin
        dcnt <= dcnt - 1;
        if (dcnt == 1) xfer_done <= 1'b1;
      end
    end

  // pulse counters
  int c_irq, c_bt, c_dead, c_wake, c_aclr, c_xs, c_req_cyc;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      c_irq <= 0; c_bt <= 0; c_dead <= 0; c_wake <= 0; c_aclr <= 0; c_xs <= 0; c_req_cyc <= 0;
    end else begin
      c_irq <= c_irq + int'(irq);   c_bt   <= c_bt + int'(bt_set);
      c_dead <= c_dead + int'(dead_set); c_wake <= c_wake + int'(wake_clr);
      c_aclr <= c_aclr + int'(active_clr); c_xs <= c_xs + int'(xfer_start);
      c_req_cyc <= c_req_cyc + int'(mem_req);
    end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  function automatic logic [15:0] mkcmd(input logic [3:0] op, input logic [2:0] key,
                                        input logic [1:0] is, input logic [1:0] bs, input logic [1:0] ws);
    return {op, 1'b0, key, 2'b00, is, bs, ws};
  endfunction

  function automatic bit sel_fire(input logic [1:0] s, input bit c);
    case (s)
      2'd0: return 1'b0;
      2'd1: return c;
      2'd2: return !c;
      default: return 1'b1;
    endcase
  endfunction

  task automatic put_desc(input logic [31:0] a, input logic [15:0] req, input logic [15:0] cmd,
                          input logic [31:0] daddr, input logic [31:0] dep, input logic [31:0] w3);
    mem[a[11:2]]     = {cmd, req};
    mem[a[11:2] + 1] = daddr;
    mem[a[11:2] + 2] = dep;
    mem[a[11:2] + 3] = w3;
  endtask

  task automatic put_stop(input logic [31:0] a);
    put_desc(a, 16'd0, mkcmd(4'd7, 3'd0, 2'd0, 2'd0, 2'd0), 32'd0, 32'd0, 32'hDEADBEEF);
  endtask

  task automatic start_at(input logic [31:0] p);
    @(negedge clk); ptr_load = 1'b1; ptr_wr = p;
    @(negedge clk); ptr_load = 1'b0; act_set = 1'b1;
    @(negedge clk); act_set = 1'b0;
  endtask

  task automatic wait_inactive(input string tag);
    int n = 0;
    while (active_q && n < 3000) begin @(negedge clk); n++; end
    if (n >= 3000) chk(1'b0, {tag, " timeout"}, 32'(n), 32'd0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  int w0, x0, i0, b0, d0, a0;
  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; run_r = 1'b0; act_set = 1'b0; dev_r = 4'd0;
    ptr_load = 1'b0; ptr_wr = '0;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (4) @(negedge clk);
    // R13 reset state
    chk_eq("R13 ptr", cmd_ptr, 0);
    chk_eq("R13 outs", {mem_req, xfer_start, irq, wake_clr, bt_set, dead_set, active_clr}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: active without run, then run without active
    put_stop(32'h0);
    act_set = 1'b1; @(negedge clk); act_set = 1'b0;
    repeat (20) @(negedge clk);
    chk_eq("R2 no fetch without run", c_req_cyc, 0);
    run_r = 1'b1;
    wait_inactive("R2");
    w0 = c_req_cyc;
    repeat (20) @(negedge clk);
    chk_eq("R2 no fetch without active", c_req_cyc, w0);

    // R3 R5 R7 R1 R10: output-last, then stop
    put_desc(32'h100, 16'd64, mkcmd(4'd1, 3'd0, 2'd3, 2'd0, 2'd0), 32'h800, 32'h0, 32'h0);
    put_stop(32'h110);
    dev_r = 4'd5; xfer_resid = 16'd7;
    w0 = c_wake; x0 = c_xs; i0 = c_irq;
    start_at(32'h100);
    wait_inactive("R3");
    chk_eq("R3 xfer count", c_xs - x0, 1);
    chk_eq("R3 xfer addr", cap_addr, 32'h800);
    chk_eq("R3 xfer len", cap_len, 16'd64);
    chk_eq("R3 dir/last", {cap_in, cap_last}, 2'b01);
    chk_eq("R5 writeback", mem[32'h10C >> 2], 32'h8405_0007);
    chk_eq("R7 irq always", c_irq - i0, 1);
    chk_eq("R1 one wake per fetch", c_wake - w0, 2);
    chk_eq("R10 stop pointer", cmd_ptr, 32'h110);
    chk_eq("R10 stop untouched", mem[32'h11C >> 2], 32'hDEADBEEF);

    // R6 R9: input-more, branch if true, irq if false; cond true
    put_desc(32'h140, 16'd10, mkcmd(4'd2, 3'd3, 2'd2, 2'd1, 2'd0), 32'h900, 32'h0001_0200, 32'h0);
    put_stop(32'h150); put_stop(32'h200);
    dev_r = 4'd0; i0 = c_irq; b0 = c_bt;
    start_at(32'h140);
    wait_inactive("R9a");
    chk_eq("R9 branch taken ptr", cmd_ptr, 32'h0001_0200);
    chk_eq("R9 bt pulse", c_bt - b0, 1);
    chk_eq("R7 no irq when sel false", c_irq - i0, 0);
    chk_eq("R3 input more dir/last", {cap_in, cap_last}, 2'b10);
    // cond false
    dev_r = 4'd1; i0 = c_irq; b0 = c_bt;
    start_at(32'h140);
    wait_inactive("R9b");
    chk_eq("R9 sequential ptr", cmd_ptr, 32'h150);
    chk_eq("R6 irq on cond false", c_irq - i0, 1);
    chk_eq("R6 no bt", c_bt - b0, 0);

    // R4 kills
    put_desc(32'h180, 16'd8, mkcmd(4'd0, 3'd0, 2'd3, 2'd3, 2'd0), 32'h0, 32'h0, 32'hDEADBEEF);
    d0 = c_dead; x0 = c_xs; i0 = c_irq;
    start_at(32'h180);
    wait_inactive("R4a");
    chk_eq("R4 dead on zero addr", c_dead - d0, 1);
    chk_eq("R4 no xfer", c_xs - x0, 0);
    chk_eq("R4 no irq", c_irq - i0, 0);
    chk_eq("R4 ptr stays", cmd_ptr, 32'h180);
    chk_eq("R4 no writeback", mem[32'h18C >> 2], 32'hDEADBEEF);
    put_desc(32'h1C0, 16'd8, mkcmd(4'd3, 3'd4, 2'd0, 2'd0, 2'd0), 32'h900, 32'h0, 32'h0);
    d0 = c_dead;
    start_at(32'h1C0);
    wait_inactive("R4b");
    chk_eq("R4 dead on key 4", c_dead - d0, 1);
    put_desc(32'h1C0, 16'd8, mkcmd(4'd9, 3'd0, 2'd0, 2'd0, 2'd0), 32'h900, 32'h0, 32'h0);
    d0 = c_dead;
    start_at(32'h1C0);
    wait_inactive("R4c");
    chk_eq("R4 dead on opcode 9", c_dead - d0, 1);
    chk_eq("R4 ptr after bad op", cmd_ptr, 32'h1C0);

    // R8 R12: wait if true, cond true while dev bit1 clear
    put_desc(32'h300, 16'd0, mkcmd(4'd6, 3'd0, 2'd0, 2'd0, 2'd1), 32'h0, 32'h0002_0000, 32'h0);
    put_stop(32'h310);
    dev_r = 4'd0; w0 = c_wake;
    start_at(32'h300);
    repeat (40) @(negedge clk);
    chk_eq("R8 holds ptr", cmd_ptr, 32'h300);
    chk_eq("R8 still active", active_q, 1'b1);
    chk_eq("R8 no refetch", c_wake - w0, 1);
    ptr_load = 1'b1; ptr_wr = 32'hF00; @(negedge clk); ptr_load = 1'b0;
    repeat (3) @(negedge clk);
    chk_eq("R12 load ignored while busy", cmd_ptr, 32'h300);
    dev_r = 4'd2;
    wait_inactive("R8a");
    chk_eq("R8 advance after release", cmd_ptr, 32'h310);

    // R8: wait always, then RUN drops
    put_desc(32'h400, 16'd0, mkcmd(4'd6, 3'd0, 2'd0, 2'd3, 2'd3), 32'h0, 32'h0, 32'h0);
    start_at(32'h400);
    repeat (30) @(negedge clk);
    run_r = 1'b0;
    repeat (5) @(negedge clk);
    w0 = c_wake; a0 = c_req_cyc;
    repeat (20) @(negedge clk);
    chk_eq("R8 drop: ptr kept", cmd_ptr, 32'h400);
    chk_eq("R2 drop: no fetch", c_req_cyc - a0, 0);
    put_stop(32'h400);
    run_r = 1'b1;
    wait_inactive("R8b");
    chk_eq("R8 refetch same descriptor", cmd_ptr, 32'h400);
    chk_eq("R8 refetch wake", c_wake - w0, 1);

    // R11 load half-word at offset 2
    put_desc(32'h500, 16'd2, mkcmd(4'd5, 3'd6, 2'd0, 2'd0, 2'd0), 32'h602, 32'hAABBCCDD, 32'h0);
    put_stop(32'h510);
    mem[32'h600 >> 2] = 32'h11223344;
    start_at(32'h500);
    wait_inactive("R11a");
    chk_eq("R11 load dep writeback", mem[32'h508 >> 2], 32'hAABB1122);
    chk_eq("R11 load ptr", cmd_ptr, 32'h510);

    // R11 R9 store byte at offset 1, branch always ignored
    put_desc(32'h540, 16'd1, mkcmd(4'd4, 3'd6, 2'd3, 2'd3, 2'd0), 32'h701, 32'h0000_00EE, 32'h0);
    put_stop(32'h550);
    mem[32'h700 >> 2] = 32'h0;
    b0 = c_bt; i0 = c_irq;
    start_at(32'h540);
    wait_inactive("R11b");
    chk_eq("R11 store byte lane", mem[32'h700 >> 2], 32'h0000EE00);
    chk_eq("R9 word cmd sequential", cmd_ptr, 32'h550);
    chk_eq("R9 word cmd no bt", c_bt - b0, 0);
    chk_eq("R7 irq after store", c_irq - i0, 1);

    // R11 non-system key: no access
    put_desc(32'h580, 16'd4, mkcmd(4'd5, 3'd0, 2'd0, 2'd0, 2'd0), 32'h600, 32'h12345678, 32'h0);
    put_stop(32'h590);
    w0 = n_wr;
    start_at(32'h580);
    wait_inactive("R11c");
    chk_eq("R11 key0 dep unchanged", mem[32'h588 >> 2], 32'h12345678);
    chk_eq("R11 key0 no write", n_wr - w0, 0);
    chk_eq("R11 key0 steps", cmd_ptr, 32'h590);

    // R6 R7 R9 random no-ops
    for (int it = 0; it < 24; it++) begin
      logic [1:0] is, bs; logic [3:0] msk, dv; bit c; logic [31:0] tgt, expp;
      is = 2'($urandom); bs = 2'($urandom); msk = 4'($urandom); dv = 4'($urandom);
      tgt = {12'h000, msk, 16'h0B00};
      c = ((dv & msk) == 4'd0);
      expp = sel_fire(bs, c) ? tgt : 32'hA10;
      put_desc(32'hA00, 16'd0, mkcmd(4'd6, 3'd0, is, bs, 2'd0), 32'h0, tgt, 32'h0);
      put_stop(32'hA10); put_stop(32'hB00);
      dev_r = dv; i0 = c_irq;
      start_at(32'hA00);
      wait_inactive("R9r");
      chk_eq("R9 random ptr", cmd_ptr, expp);
      chk_eq("R6 random irq", c_irq - i0, 32'(sel_fire(is, c)));
    end

    done_flag = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule